// File: doc/BRIEF.md
# Sensor Readout Position Counter

This block follows the readout of one frame from an interline area image sensor and tells the downstream pipeline where each pixel sits. It runs on the pixel clock. A pixel enable advances the position within a line. A line start pulse begins a new line, and a frame start pulse begins a new frame. For every position it raises exactly one of five region flags: blanking, dummy transfer, front optical black, effective pixel, or rear optical black. It also reports the column and row inside the effective area.

Each axis is an enumerated state machine with the states RG_BLANK, RG_DUMMY, RG_OB_FRONT, RG_EFF and RG_OB_REAR. A start pulse moves the axis from any state to RG_DUMMY (transition START). Advancing past the last slot of a region moves it to the next region in a fixed order: DUMMY_DONE (RG_DUMMY to RG_OB_FRONT), OBF_DONE (RG_OB_FRONT to RG_EFF), EFF_DONE (RG_EFF to RG_OB_REAR) and OBR_DONE (RG_OB_REAR to RG_BLANK). RG_BLANK is left only through START, and reset enters RG_BLANK.

Horizontally a line holds 19 dummy slots, 3 front optical black pixels, 782 effective pixels and 38 rear optical black pixels, for 842 slots in all. Vertically a frame holds 5 dummy lines, 8 front optical black lines, 582 effective lines and 2 rear optical black lines, for 597 lines. The rest of the 625-line frame period is blanking. A classifier combines the two axes, and a small hold stage keeps the effective coordinates steady outside the effective area.

Top module: `sensor_readout_pos`

## Requirements
- R1: After reset, is_blank is 1, the other four flags are 0, and pix_pos, line_pos, eff_col and eff_row are 0. Pixel enable pulses before any start keep the block in blanking, while pix_pos still counts them.
- R2: One cycle after line_start or frame_start, pix_pos is 0 and the horizontal region is dummy. A line_start in the middle of a line restarts the line.
- R3: pix_pos increments by one on each cycle with pix_enable high and no start pulse, and it saturates at 1023.
- R4: frame_start sets line_pos to 0. Each line_start without frame_start adds one, saturating at 624. Vertical regions are: lines 0-4 dummy, 5-12 front optical black, 13-594 effective, 595-596 rear optical black, and 597 and above blanking.
- R5: When frame_start and line_start are high in the same cycle, frame_start wins, and line_pos is 0 on the next cycle.
- R6: Exactly one flag is high in every cycle. The priority is blanking, then dummy, then front optical black, then rear optical black, then effective. Horizontal regions by pix_pos are: 0-18 dummy, 19-21 front optical black, 22-803 effective, 804-841 rear optical black, and 842 and above blanking.
- R7: While is_eff is high, eff_col is pix_pos-22 and eff_row is line_pos-13. While is_eff is low, both hold their last value.
- R8: A cycle with pix_enable, line_start and frame_start all low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_enable | input | 1 | Advances the horizontal position |
| line_start | input | 1 | Begins a new line |
| frame_start | input | 1 | Begins a new frame; wins over line_start |
| is_blank | output | 1 | Position lies outside all defined regions |
| is_dummy | output | 1 | Dummy transfer position |
| is_ob_front | output | 1 | Front optical black |
| is_eff | output | 1 | Effective pixel |
| is_ob_rear | output | 1 | Rear optical black |
| pix_pos | output | 10 | Horizontal slot index within the line |
| line_pos | output | 10 | Line index within the frame |
| eff_col | output | 10 | Column within the effective area |
| eff_row | output | 10 | Row within the effective area |

## Verification
The assertions check these properties on every cycle:
- a start pulse lands each axis in dummy at position zero;
- an axis only stays put or steps to its successor region;
- idle cycles change nothing;
- the flags stay one-hot;
- frame start wins over line start;
- the effective coordinates hold outside the effective area.

Only the bench's scenarios can show the exact boundary positions. These are the column and line where each region begins and ends, the zero origin of the effective coordinates, and saturation at 1023 pixels and 624 lines. The bench walks a full line, every line of a frame, and the start collisions against its own position model.

// File: rtl/rdpos_pkg.sv
package rdpos_pkg;

    typedef enum logic [2:0] {
        RG_BLANK    = 3'd0,
        RG_DUMMY    = 3'd1,
        RG_OB_FRONT = 3'd2,
        RG_EFF      = 3'd3,
        RG_OB_REAR  = 3'd4
    } region_t;

endpackage

// File: rtl/rdpos_axis.sv
module rdpos_axis
    import rdpos_pkg::*;
#(
    parameter int N_DUMMY    = 19,
    parameter int N_OB_FRONT = 3,
    parameter int N_EFF      = 782,
    parameter int N_OB_REAR  = 38,
    parameter int POS_MAX    = 1023,
    parameter int W          = $clog2(POS_MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         adv,
    output region_t      region,
    output logic [W-1:0] seg_idx,
    output logic [W-1:0] pos
);

    localparam logic [W-1:0] LAST_DUMMY = W'(N_DUMMY - 1);
    localparam logic [W-1:0] LAST_OBF   = W'(N_OB_FRONT - 1);
    localparam logic [W-1:0] LAST_EFF   = W'(N_EFF - 1);
    localparam logic [W-1:0] LAST_OBR   = W'(N_OB_REAR - 1);
    localparam logic [W-1:0] POS_TOP    = W'(POS_MAX);

    region_t      state, state_nx;
    logic [W-1:0] seg, seg_nx, seg_last;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RG_BLANK;
        end else begin
            state <= state_nx;
        end
    end

    // Last slot of the current region
    always_comb begin
        unique case (state)
            RG_DUMMY:    seg_last = LAST_DUMMY;
            RG_OB_FRONT: seg_last = LAST_OBF;
            RG_EFF:      seg_last = LAST_EFF;
            RG_OB_REAR:  seg_last = LAST_OBR;
            default:     seg_last = '0;
        endcase
    end

    // Next state and in-region counter
    always_comb begin
        state_nx = state;
        seg_nx   = seg;
        if (start) begin
            state_nx = RG_DUMMY;
            seg_nx   = '0;
        end else if (adv && state != RG_BLANK) begin
            if (seg == seg_last) begin
                seg_nx = '0;
                unique case (state)
                    RG_DUMMY:    state_nx = RG_OB_FRONT;
                    RG_OB_FRONT: state_nx = RG_EFF;
                    RG_EFF:      state_nx = RG_OB_REAR;
                    RG_OB_REAR:  state_nx = RG_BLANK;
                    default:     state_nx = RG_BLANK;
                endcase
            end else begin
                seg_nx = seg + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg <= '0;
            pos <= '0;
        end else begin
            seg <= seg_nx;
            if (start) begin
                pos <= '0;
            end else if (adv && pos != POS_TOP) begin
                pos <= pos + W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        region  = state;
        seg_idx = seg;
    end

    // R2
    start_to_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == RG_DUMMY && pos == '0 && seg == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !adv) |=> ($stable(state) && $stable(pos) && $stable(seg)));

    // R3
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && adv && pos != POS_TOP) |=> (pos == $past(pos) + W'(1)));

    // R6
    region_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && adv) |=> (state == $past(state)
            || ($past(state) == RG_DUMMY    && state == RG_OB_FRONT)
            || ($past(state) == RG_OB_FRONT && state == RG_EFF)
            || ($past(state) == RG_EFF      && state == RG_OB_REAR)
            || ($past(state) == RG_OB_REAR  && state == RG_BLANK)));

endmodule

// File: rtl/rdpos_classify.sv
module rdpos_classify
    import rdpos_pkg::*;
(
    input  region_t h_region,
    input  region_t v_region,
    output logic    blank,
    output logic    dummy,
    output logic    ob_front,
    output logic    eff,
    output logic    ob_rear
);

    always_comb begin
        blank    = 1'b0;
        dummy    = 1'b0;
        ob_front = 1'b0;
        eff      = 1'b0;
        ob_rear  = 1'b0;
        if (h_region == RG_BLANK || v_region == RG_BLANK) begin
            blank = 1'b1;
        end else if (h_region == RG_DUMMY || v_region == RG_DUMMY) begin
            dummy = 1'b1;
        end else if (h_region == RG_OB_FRONT || v_region == RG_OB_FRONT) begin
            ob_front = 1'b1;
        end else if (h_region == RG_OB_REAR || v_region == RG_OB_REAR) begin
            ob_rear = 1'b1;
        end else begin
            eff = 1'b1;
        end
    end

endmodule

// File: rtl/sensor_readout_pos.sv
module sensor_readout_pos
    import rdpos_pkg::*;
#(
    parameter int H_DUMMY     = 19,
    parameter int H_OB_FRONT  = 3,
    parameter int H_EFF       = 782,
    parameter int H_OB_REAR   = 38,
    parameter int H_POS_MAX   = 1023,
    parameter int V_DUMMY     = 5,
    parameter int V_OB_FRONT  = 8,
    parameter int V_EFF       = 582,
    parameter int V_OB_REAR   = 2,
    parameter int FRAME_LINES = 625,
    parameter int HW          = $clog2(H_POS_MAX + 1),
    parameter int VW          = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_enable,
    input  logic          line_start,
    input  logic          frame_start,
    output logic          is_blank,
    output logic          is_dummy,
    output logic          is_ob_front,
    output logic          is_eff,
    output logic          is_ob_rear,
    output logic [HW-1:0] pix_pos,
    output logic [VW-1:0] line_pos,
    output logic [HW-1:0] eff_col,
    output logic [VW-1:0] eff_row
);

    region_t       h_region, v_region;
    logic [HW-1:0] h_seg, col_q;
    logic [VW-1:0] v_seg, row_q;
    logic          h_start, h_adv, v_adv;

    assign h_start = line_start | frame_start;
    assign h_adv   = pix_enable & ~h_start;
    assign v_adv   = line_start & ~frame_start;

    rdpos_axis #(
        .N_DUMMY(H_DUMMY), .N_OB_FRONT(H_OB_FRONT), .N_EFF(H_EFF),
        .N_OB_REAR(H_OB_REAR), .POS_MAX(H_POS_MAX), .W(HW)
    ) u_h_axis (
        .clk(clk), .rst_n(rst_n), .start(h_start), .adv(h_adv),
        .region(h_region), .seg_idx(h_seg), .pos(pix_pos)
    );

    rdpos_axis #(
        .N_DUMMY(V_DUMMY), .N_OB_FRONT(V_OB_FRONT), .N_EFF(V_EFF),
        .N_OB_REAR(V_OB_REAR), .POS_MAX(FRAME_LINES - 1), .W(VW)
    ) u_v_axis (
        .clk(clk), .rst_n(rst_n), .start(frame_start), .adv(v_adv),
        .region(v_region), .seg_idx(v_seg), .pos(line_pos)
    );

    rdpos_classify u_classify (
        .h_region(h_region), .v_region(v_region),
        .blank(is_blank), .dummy(is_dummy), .ob_front(is_ob_front),
        .eff(is_eff), .ob_rear(is_ob_rear)
    );

    // Hold of the effective coordinates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (is_eff) begin
            col_q <= h_seg;
            row_q <= v_seg;
        end
    end

    always_comb begin
        eff_col = is_eff ? h_seg : col_q;
        eff_row = is_eff ? v_seg : row_q;
    end

    // R6
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_blank, is_dummy, is_ob_front, is_eff, is_ob_rear}) == 1);

    // R5
    frame_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_pos == '0 && pix_pos == '0));

    // R7
    eff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_eff |=> (is_eff || ($stable(eff_col) && $stable(eff_row))));

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_adv && line_pos != VW'(FRAME_LINES - 1)) |=> (line_pos == $past(line_pos) + VW'(1)));

endmodule

// File: tb/sensor_readout_pos_bench.sv
module sensor_readout_pos_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_enable = 1'b0;
    logic line_start = 1'b0;
    logic frame_start = 1'b0;
    logic is_blank, is_dummy, is_ob_front, is_eff, is_ob_rear;
    logic [9:0] pix_pos, line_pos, eff_col, eff_row;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model
    int  mh = 0, mv = 0;
    bit  hs = 0, vs = 0;
    int  held_col = 0, held_row = 0;

    always #2.5 clk = ~clk;

    sensor_readout_pos u_sensor_readout_pos (
        .clk(clk), .rst_n(rst_n), .pix_enable(pix_enable),
        .line_start(line_start), .frame_start(frame_start),
        .is_blank(is_blank), .is_dummy(is_dummy), .is_ob_front(is_ob_front),
        .is_eff(is_eff), .is_ob_rear(is_ob_rear),
        .pix_pos(pix_pos), .line_pos(line_pos),
        .eff_col(eff_col), .eff_row(eff_row)
    );

    // region codes: 0 blank, 1 dummy, 2 front OB, 3 effective, 4 rear OB
    function automatic int h_code(int h, bit st);
        if (!st) return 0;
        if (h < 19) return 1;
        if (h < 22) return 2;
        if (h < 804) return 3;
        if (h < 842) return 4;
        return 0;
    endfunction

    function automatic int v_code(int v, bit st);
        if (!st) return 0;
        if (v < 5) return 1;
        if (v < 13) return 2;
        if (v < 595) return 3;
        if (v < 597) return 4;
        return 0;
    endfunction

    function automatic int combine(int a, int b);
        if (a == 0 || b == 0) return 0;
        if (a == 1 || b == 1) return 1;
        if (a == 2 || b == 2) return 2;
        if (a == 4 || b == 4) return 4;
        return 3;
    endfunction

    function automatic int dut_code();
        case ({is_blank, is_dummy, is_ob_front, is_eff, is_ob_rear})
            5'b10000: return 0;
            5'b01000: return 1;
            5'b00100: return 2;
            5'b00010: return 3;
            5'b00001: return 4;
            default:  return 7;
        endcase
    endfunction

    task automatic cmp(string ctx, string req, string fld, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s %s act=%0d exp=%0d", ctx, req, fld, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        int r;
        r = combine(h_code(mh, hs), v_code(mv, vs));
        if (r == 3) begin
            held_col = mh - 22;
            held_row = mv - 13;
        end
        cmp(ctx, "R6", "region", dut_code(), r);
        cmp(ctx, "R3", "pix_pos", int'(pix_pos), mh);
        cmp(ctx, "R4", "line_pos", int'(line_pos), mv);
        cmp(ctx, "R7", "eff_col", int'(eff_col), held_col);
        cmp(ctx, "R7", "eff_row", int'(eff_row), held_row);
    endtask

    task automatic tick(bit en, bit ls, bit fs, string ctx);
        @(negedge clk);
        pix_enable  = en;
        line_start  = ls;
        frame_start = fs;
        @(posedge clk);
        #1;
        if (fs) begin
            mh = 0; mv = 0; hs = 1; vs = 1;
        end else if (ls) begin
            mh = 0; hs = 1;
            if (mv < 624) mv++;
        end else if (en) begin
            if (mh < 1023) mh++;
        end
        check_all(ctx);
    endtask

    task automatic t_reset();
        check_all("R1 reset");
        for (int i = 0; i < 30; i++) tick(1, 0, 0, "R1 enable before start");
        for (int i = 0; i < 3; i++) tick(0, 0, 0, "R8 idle before start");
    endtask

    task automatic t_line_sweep();
        tick(0, 0, 1, "R2 frame start");
        for (int i = 0; i < 13; i++) tick(0, 1, 0, "R4 advance to first effective line");
        tick(0, 1, 0, "R2 line start");
        for (int i = 0; i < 870; i++) tick((i % 40) != 7, 0, 0, "R6 R8 line sweep");
        for (int i = 0; i < 300; i++) tick(1, 0, 0, "R2 partial line");
        tick(0, 1, 0, "R2 restart mid line");
        for (int i = 0; i < 40; i++) tick(1, 0, 0, "R7 restarted line");
    endtask

    task automatic t_vertical();
        tick(0, 0, 1, "R4 frame start");
        for (int i = 0; i < 22; i++) tick(1, 0, 0, "R4 line zero");
        for (int l = 0; l < 630; l++) begin
            tick(0, 1, 0, "R4 next line");
            for (int i = 0; i < 23; i++) tick(1, 0, 0, "R4 R7 into effective column");
        end
    endtask

    task automatic t_collide();
        for (int i = 0; i < 4; i++) tick(0, 1, 0, "R5 setup lines");
        for (int i = 0; i < 25; i++) tick(1, 0, 0, "R5 setup pixels");
        tick(1, 1, 1, "R5 frame and line start together");
        tick(0, 1, 0, "R5 line after collision");
    endtask

    task automatic t_hsat();
        tick(0, 0, 1, "R3 frame start");
        for (int i = 0; i < 13; i++) tick(0, 1, 0, "R3 lines");
        for (int i = 0; i < 1100; i++) tick(1, 0, 0, "R3 saturation");
    endtask

    initial begin
        #200000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_line_sweep();
        t_collide();
        t_hsat();
        t_vertical();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule